// File: doc/BRIEF.md
# Serial ADC Digital Front End

This block is the device-side digital logic of an eight-input, 12-bit successive-approximation converter. A host drives a chip-select, a serial clock and a serial data line. The block accepts a control word, picks the analog input routing, and opens and closes the track/hold switch. It then runs a bit-by-bit search against an external comparator and returns the result on a serial data output. A separate strobe pin tells the host where the conversion is.

The host can set the conversion pace in two ways. In external-clock mode the host's serial clock drives each decision. In internal-clock mode a divider on the block's own clock drives them. The block samples the serial pins with its system clock and acts on the detected edges. The analog mux, the DAC and the comparator are outside the block. They see `dacCode`, the select outputs and the track/hold controls, and they answer on `cmpIn`.

Top module: `serial_adc_front`

## Requirements
- R1: Control bits enter on serial-clock rising edges while chip-select is low. Zeros before the first 1 are ignored, and that 1 is the start bit. The 8-bit word is sent MSB first: bit 7 start, bit 6 input type (1 single-ended, 0 pseudo-differential), bits 5:3 channel, bit 2 pacing (1 external clock, 0 internal clock), bits 1:0 unused.
- R2: Serial-clock edges and data seen while chip-select is high start nothing. No track, no hold and no conversion result follow from them.
- R3: From the 5th falling edge after the start bit, `posSel` equals the channel. In single-ended mode `negGnd`=1 and `negSel`=0. In differential mode `negGnd`=0 and `negSel` is the channel with its LSB inverted, which gives the fixed pairs 0/1, 2/3, 4/5 and 6/7.
- R4: `trackOn` is high from the 5th to the 8th falling edge, which is three serial-clock periods. `holdOn` rises on the 8th falling edge and falls after the last bit decision. The two are never high together.
- R5: In external-clock mode `strobe` is high from the 8th to the 9th falling edge and low at every other time during the conversion.
- R6: The result is found by successive approximation, one bit per step from MSB to LSB. `dacCode` shows the trial code, and `cmpIn`=1 at a step keeps that step's trial bit. The 12-bit result equals the code a comparator `cmpIn = (vin >= dacCode)` converges to.
- R7: In external-clock mode, falling edges 9 to 20 make the decisions. DOUT carries the MSB from falling edge 10 and the LSB from falling edge 21. The block re-arms on falling edge 22, so the span from hold to the next possible start bit is 15 serial clocks.
- R8: In internal-clock mode `strobe` drops at the 8th falling edge. There is one decision every INT_DIV system clocks. `strobe` rises with the MSB on DOUT when the search ends. Each later serial falling edge presents the next bit. `strobe` stays high until the next start bit.
- R9: After the LSB, DOUT reads 0 until chip-select rises or a new start bit arrives.
- R10: While chip-select is high, `doutOe` and `strobeOe` are 0. A chip-select rise during a transaction clears track, hold and strobe and returns the block to idle. The next transaction then works normally.
- R11: While `shutdown` is high the block stays idle, ignores serial traffic and deasserts both output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the internal conversion clock source |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from host |
| din | input | 1 | Serial control data |
| shutdown | input | 1 | Forces idle and ignores the serial port |
| cmpIn | input | 1 | Comparator decision: input at or above `dacCode` |
| dout | output | 1 | Serial result data |
| doutOe | output | 1 | Output enable for `dout` |
| strobe | output | 1 | Conversion strobe |
| strobeOe | output | 1 | Output enable for `strobe` |
| trackOn | output | 1 | Track/hold switch closed (acquiring) |
| holdOn | output | 1 | Sample held for conversion |
| dacCode | output | 12 | Trial code for the capacitive DAC |
| posSel | output | 3 | Positive input channel select |
| negSel | output | 3 | Negative input channel select (differential) |
| negGnd | output | 1 | Negative input tied to ground |

## Verification
The bench targets these cases:
- **Result extremes.** It converts full-scale, zero and mid-scale codes. A search that drops the last step or inverts the comparator sense returns a code one LSB off, or the complement.
- **Leading zeros.** It sends zeros ahead of the start bit. A design that treats the first clock as the start bit decodes a shifted, wrong channel.
- **Differential routing.** It uses both even and odd channels in differential mode. A wrong pair mapping shows up on `negSel`.
- **Abort, shutdown and serial-port enable.** It raises chip-select in the middle of a conversion, clocks traffic during shutdown, and clocks traffic with chip-select high. A design that keeps state across these cases leaves hold asserted, drives the pins, or corrupts the next conversion.
- **Edge-exact timing.** It checks the strobe pulse, the three-period track window and the zero padding at the exact serial edge each requirement names. An off-by-one counter moves one of them by a full period.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;
  // Control-word layout (bit positions within the 8-bit word, MSB first on the wire)
  localparam int CW_BITS   = 8;
  localparam int CH_W      = 3;
  localparam int F_START   = 7;
  localparam int F_SGL     = 6;
  localparam int F_CH_HI   = 5;
  localparam int F_CH_LO   = 3;
  localparam int F_EXT     = 2;
  // falling edge (counted from the start bit) on which the channel is complete
  localparam int TRACK_FALL = 5;
  localparam int IDX_W     = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_CTRL, S_EXT, S_INT, S_OUT
  } feState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             ctlShift;
    logic             muxLatch;
    logic             sarInit;
    logic             sarStep;
    logic             doutLoad;
    logic             doutClear;
    logic             tickClr;
    logic [IDX_W-1:0] bitIdx;
  } dpCtl_t;
endpackage

// File: rtl/adcfe_dp.sv
module adcfe_dp
  import adcfe_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int INT_DIV  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                din,
  input  logic                cmpIn,
  input  dpCtl_t              ctl,
  output logic                extSel,
  output logic                tick,
  output logic                dout,
  output logic [RES_BITS-1:0] dacCode,
  output logic [CH_W-1:0]     posSel,
  output logic [CH_W-1:0]     negSel,
  output logic                negGnd
);
  localparam int GAP   = CW_BITS - TRACK_FALL;
  localparam int DIV_W = (INT_DIV > 2) ? $clog2(INT_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(INT_DIV - 1);
  localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [CW_BITS-1:0]  shReg;
  logic [RES_BITS-1:0] sarReg;
  logic [RES_BITS-1:0] maskReg;
  logic [RES_BITS-1:0] selMask;
  logic [DIV_W-1:0]    divCnt;
  logic                partSgl;
  logic [CH_W-1:0]     partCh;

  // control word shifter
  always_ff @(posedge clk) begin
    if (!rstN) shReg <= '0;
    else if (ctl.ctlShift) shReg <= {shReg[CW_BITS-2:0], din};
  end

  assign extSel  = shReg[F_EXT];
  assign partSgl = shReg[F_SGL - GAP];
  assign partCh  = shReg[F_CH_HI - GAP : F_CH_LO - GAP];

  // input routing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      posSel <= '0;
      negSel <= '0;
      negGnd <= 1'b1;
    end else if (ctl.muxLatch) begin
      posSel <= partCh;
      negSel <= partSgl ? '0 : {partCh[CH_W-1:1], ~partCh[0]};
      negGnd <= partSgl;
    end
  end

  // successive-approximation register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sarReg  <= '0;
      maskReg <= '0;
    end else if (ctl.sarInit) begin
      sarReg  <= TOP_BIT;
      maskReg <= TOP_BIT;
    end else if (ctl.sarStep) begin
      sarReg  <= (cmpIn ? sarReg : (sarReg & ~maskReg)) | (maskReg >> 1);
      maskReg <= maskReg >> 1;
    end
  end

  assign dacCode = sarReg;

  // internal conversion clock divider
  always_ff @(posedge clk) begin
    if (!rstN || ctl.tickClr) divCnt <= '0;
    else if (divCnt == DIV_MAX) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  assign tick = (divCnt == DIV_MAX);

  // serial output bit
  assign selMask = RES_BITS'(1) << ctl.bitIdx;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.doutClear) dout <= 1'b0;
    else if (ctl.doutLoad) dout <= |(sarReg & selMask);
  end

  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(maskReg)); // R6
  AST_START_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sarInit |-> shReg[F_START]); // R1
endmodule

// File: rtl/adcfe_ctl.sv
module adcfe_ctl
  import adcfe_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclk,
  input  logic   csN,
  input  logic   din,
  input  logic   shutdown,
  input  logic   extSel,
  input  logic   tick,
  output dpCtl_t ctl,
  output logic   trackOn,
  output logic   holdOn,
  output logic   strobe
);
  typedef logic [IDX_W-1:0] cnt_t;
  localparam cnt_t TRACK_N   = cnt_t'(TRACK_FALL);
  localparam cnt_t HOLD_N    = cnt_t'(CW_BITS);
  localparam cnt_t FIRST_DEC = cnt_t'(CW_BITS + 1);
  localparam cnt_t LAST_DEC  = cnt_t'(CW_BITS + RES_BITS);
  localparam cnt_t FIRST_OUT = cnt_t'(CW_BITS + 2);
  localparam cnt_t LAST_OUT  = cnt_t'(CW_BITS + RES_BITS + 1);
  localparam cnt_t REARM_N   = cnt_t'(CW_BITS + RES_BITS + 2);
  localparam cnt_t LAST_STEP = cnt_t'(RES_BITS - 1);
  localparam cnt_t OUT_TOP   = cnt_t'(RES_BITS - 2);

  feState_t state;
  cnt_t     fallCnt;
  cnt_t     stepCnt;
  cnt_t     nextFall;
  logic     sclkQ;
  logic     abort;
  logic     sclkRise;
  logic     sclkFall;

  assign abort    = csN | shutdown;
  assign sclkRise = sclk & ~sclkQ & ~abort;
  assign sclkFall = ~sclk & sclkQ & ~abort;
  assign nextFall = fallCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) sclkQ <= 1'b0;
    else sclkQ <= sclk;
  end

  // datapath strobes
  always_comb begin
    ctl = '0;
    if (abort) begin
      ctl.doutClear = 1'b1;
    end else begin
      unique case (state)
        S_IDLE: ctl.ctlShift = sclkRise & din;
        S_CTRL: begin
          ctl.ctlShift = sclkRise;
          ctl.muxLatch = sclkFall && (nextFall == TRACK_N);
          ctl.sarInit  = sclkFall && (nextFall == HOLD_N);
          ctl.tickClr  = sclkFall && (nextFall == HOLD_N);
        end
        S_EXT: if (sclkFall) begin
          ctl.sarStep   = (nextFall >= FIRST_DEC) && (nextFall <= LAST_DEC);
          ctl.doutLoad  = (nextFall >= FIRST_OUT) && (nextFall <= LAST_OUT);
          ctl.bitIdx    = LAST_OUT - nextFall;
          ctl.doutClear = (nextFall == REARM_N);
        end
        S_INT: if (tick) begin
          ctl.sarStep  = 1'b1;
          ctl.doutLoad = (stepCnt == LAST_STEP);
          ctl.bitIdx   = LAST_STEP;
        end
        S_OUT: if (sclkFall) begin
          ctl.doutLoad  = (fallCnt <= OUT_TOP);
          ctl.doutClear = (fallCnt > OUT_TOP);
          ctl.bitIdx    = OUT_TOP - fallCnt;
        end
        default: ctl = '0;
      endcase
    end
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (!rstN || abort) begin
      state   <= S_IDLE;
      fallCnt <= '0;
      stepCnt <= '0;
      trackOn <= 1'b0;
      holdOn  <= 1'b0;
      strobe  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (sclkRise && din) begin
          state   <= S_CTRL;
          fallCnt <= '0;
          strobe  <= 1'b0;
        end
        S_CTRL: if (sclkFall) begin
          fallCnt <= nextFall;
          if (nextFall == TRACK_N) trackOn <= 1'b1;
          if (nextFall == HOLD_N) begin
            trackOn <= 1'b0;
            holdOn  <= 1'b1;
            stepCnt <= '0;
            strobe  <= extSel;
            state   <= extSel ? S_EXT : S_INT;
          end
        end
        S_EXT: if (sclkFall) begin
          fallCnt <= nextFall;
          if (nextFall == FIRST_DEC) strobe <= 1'b0;
          if (nextFall == LAST_DEC) holdOn <= 1'b0;
          if (nextFall == REARM_N) state <= S_IDLE;
        end
        S_INT: if (tick) begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) begin
            holdOn  <= 1'b0;
            strobe  <= 1'b1;
            fallCnt <= '0;
            state   <= S_OUT;
          end
        end
        S_OUT: if (sclkFall) begin
          fallCnt <= nextFall;
          if (fallCnt > OUT_TOP) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_TRACK_HOLD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(trackOn && holdOn)); // R4
  AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> (state == S_IDLE) && !holdOn && !strobe); // R10
  AST_SHDN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    shutdown |=> (state == S_IDLE) && !trackOn && !holdOn); // R11
  AST_EXT_STROBE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EXT && strobe && sclkFall) |=> !strobe); // R5
  AST_STEP_IN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sarStep |-> holdOn); // R6
endmodule

// File: rtl/serial_adc_front.sv
module serial_adc_front
  import adcfe_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int INT_DIV  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic                din,
  input  logic                shutdown,
  input  logic                cmpIn,
  output logic                dout,
  output logic                doutOe,
  output logic                strobe,
  output logic                strobeOe,
  output logic                trackOn,
  output logic                holdOn,
  output logic [RES_BITS-1:0] dacCode,
  output logic [CH_W-1:0]     posSel,
  output logic [CH_W-1:0]     negSel,
  output logic                negGnd
);
  dpCtl_t dpCtl;
  logic   extSel;
  logic   tick;

  adcfe_ctl #(.RES_BITS(RES_BITS)) i_ctl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .din(din),
    .shutdown(shutdown), .extSel(extSel), .tick(tick), .ctl(dpCtl),
    .trackOn(trackOn), .holdOn(holdOn), .strobe(strobe)
  );

  adcfe_dp #(.RES_BITS(RES_BITS), .INT_DIV(INT_DIV)) i_dp (
    .clk(clk), .rstN(rstN), .din(din), .cmpIn(cmpIn), .ctl(dpCtl),
    .extSel(extSel), .tick(tick), .dout(dout), .dacCode(dacCode),
    .posSel(posSel), .negSel(negSel), .negGnd(negGnd)
  );

  assign doutOe   = ~(csN | shutdown);
  assign strobeOe = ~(csN | shutdown);
endmodule

// File: tb/test_serial_adc_front.sv
module test_serial_adc_front;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic        shutdown = 1'b0;
  logic        cmpIn;
  logic [11:0] vin = '0;
  logic        dout, doutOe, strobe, strobeOe, trackOn, holdOn, negGnd;
  logic [11:0] dacCode;
  logic [2:0]  posSel, negSel;
  int          nChecks = 0;
  int          nFail = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  // comparator model: analog input at or above DAC trial
  always_comb cmpIn = (vin >= dacCode);

  serial_adc_front i_serial_adc_front (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .shutdown(shutdown), .cmpIn(cmpIn), .dout(dout), .doutOe(doutOe),
    .strobe(strobe), .strobeOe(strobeOe), .trackOn(trackOn), .holdOn(holdOn),
    .dacCode(dacCode), .posSel(posSel), .negSel(negSel), .negGnd(negGnd)
  );

  // {ext, sgl, ch, vin, expPos, expNeg, expNegGnd}
  localparam logic [23:0] VEC [0:7] = '{
    {1'b1, 1'b1, 3'd0, 12'hABC, 3'd0, 3'd0, 1'b1},
    {1'b1, 1'b0, 3'd3, 12'h000, 3'd3, 3'd2, 1'b0},
    {1'b1, 1'b0, 3'd4, 12'hFFF, 3'd4, 3'd5, 1'b0},
    {1'b0, 1'b1, 3'd7, 12'h5A5, 3'd7, 3'd0, 1'b1},
    {1'b0, 1'b0, 3'd6, 12'h800, 3'd6, 3'd7, 1'b0},
    {1'b1, 1'b1, 3'd5, 12'h7FF, 3'd5, 3'd0, 1'b1},
    {1'b0, 1'b0, 3'd1, 12'h001, 3'd1, 3'd0, 1'b0},
    {1'b1, 1'b0, 3'd2, 12'h3C3, 3'd2, 3'd3, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclkPulse();
    sclk = 1'b1; waitClk(HALF);
    sclk = 1'b0; waitClk(HALF);
  endtask

  task automatic sendWord(input logic [7:0] w, input logic [2:0] pos,
                          input logic [2:0] neg, input logic gnd, input bit chkSide);
    for (int i = 7; i >= 0; i--) begin
      din = w[i];
      sclkPulse();
      if (chkSide && (8 - i) == 5) begin
        chk("R4 track at fall 5", trackOn, 1);
        chk("R3 posSel", posSel, pos);
        chk("R3 negSel", negSel, neg);
        chk("R3 negGnd", negGnd, gnd);
      end
      if (chkSide && (8 - i) == 7) chk("R4 track still on", trackOn, 1);
    end
    din = 1'b0;
  endtask

  task automatic runConv(input logic ext, input logic sgl, input logic [2:0] ch,
                         input logic [11:0] v, input logic [2:0] pos,
                         input logic [2:0] neg, input logic gnd, input int nLead);
    logic [11:0] res;
    bit seen;
    vin = v;
    csN = 1'b0; din = 1'b0; waitClk(HALF);
    for (int k = 0; k < nLead; k++) sclkPulse();
    sendWord({1'b1, sgl, ch, ext, 2'b00}, pos, neg, gnd, 1'b1);
    chk("R4 hold at fall 8", holdOn, 1);
    chk("R4 track off at fall 8", trackOn, 0);
    res = '0;
    if (ext) begin
      chk("R5 strobe high before MSB", strobe, 1);
      for (int n = 9; n <= 22; n++) begin
        sclkPulse();
        if (n == 9) chk("R5 strobe one period", strobe, 0);
        if (n >= 10 && n <= 21) res[21 - n] = dout;
        if (n == 20) chk("R4 hold off after LSB decision", holdOn, 0);
        if (n == 22) chk("R9 zero pad", dout, 0);
      end
      sclkPulse();
      chk("R9 zero pad held", dout, 0);
      chk("R7 external result", res, v);
    end else begin
      chk("R8 strobe low at start", strobe, 0);
      seen = 1'b0;
      for (int t = 0; t < 400 && !seen; t++) begin
        @(negedge clk);
        seen = strobe;
      end
      chk("R8 strobe high at end", seen, 1);
      chk("R4 hold off at end", holdOn, 0);
      res[11] = dout;
      for (int k = 1; k <= 11; k++) begin
        sclkPulse();
        res[11 - k] = dout;
      end
      sclkPulse();
      chk("R9 zero pad internal", dout, 0);
      chk("R8 strobe stays high", strobe, 1);
      chk("R6 internal result", res, v);
    end
    csN = 1'b1; waitClk(HALF);
    chk("R10 dout tri-state", doutOe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++; nChecks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    waitClk(4);
    rstN = 1'b1;
    waitClk(2);
    // reset state
    chk("R10 reset doutOe", doutOe, 0);
    chk("R10 reset strobeOe", strobeOe, 0);
    chk("R4 reset track", trackOn, 0);
    chk("R4 reset hold", holdOn, 0);
    chk("R5 reset strobe", strobe, 0);
    chk("R9 reset dout", dout, 0);

    // table walk
    for (int i = 0; i < 8; i++)
      runConv(VEC[i][23], VEC[i][22], VEC[i][21:19], VEC[i][18:7],
              VEC[i][6:4], VEC[i][3:1], VEC[i][0], 0);

    // R1: leading zeros before the start bit
    runConv(1'b1, 1'b0, 3'd5, 12'h9E1, 3'd5, 3'd4, 1'b0, 3);

    // R2: traffic with chip select high
    csN = 1'b1; din = 1'b1;
    for (int k = 0; k < 8; k++) sclkPulse();
    din = 1'b0;
    chk("R2 no hold from traffic with CS high", holdOn, 0);
    csN = 1'b0; waitClk(HALF);
    for (int k = 0; k < 5; k++) sclkPulse();
    chk("R2 no track after CS high traffic", trackOn, 0);
    chk("R2 no hold after CS high traffic", holdOn, 0);
    csN = 1'b1; waitClk(HALF);

    // R10: abort in the middle of an external conversion
    vin = 12'h456;
    csN = 1'b0; waitClk(HALF);
    sendWord(8'b1100_0100, 3'd0, 3'd0, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) sclkPulse();
    chk("R10 hold during conversion", holdOn, 1);
    csN = 1'b1; waitClk(HALF);
    chk("R10 hold cleared by abort", holdOn, 0);
    chk("R10 strobe cleared by abort", strobe, 0);
    chk("R10 strobeOe off", strobeOe, 0);
    runConv(1'b1, 1'b1, 3'd1, 12'h2D2, 3'd1, 3'd0, 1'b1, 0);

    // R11: shutdown ignores traffic
    shutdown = 1'b1; csN = 1'b0; waitClk(HALF);
    chk("R11 doutOe off in shutdown", doutOe, 0);
    for (int i = 7; i >= 0; i--) begin
      din = (8'b1110_0100 >> i) & 1'b1;
      sclkPulse();
      if (i == 3) chk("R11 no track in shutdown", trackOn, 0);
    end
    din = 1'b0;
    chk("R11 no hold in shutdown", holdOn, 0);
    shutdown = 1'b0; csN = 1'b1; waitClk(HALF);
    runConv(1'b0, 1'b1, 3'd3, 12'hC0F, 3'd3, 3'd0, 1'b1, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule